// File: doc/BRIEF.md
# Serial Transmit Underrun Handler

This block holds the transmit-side status of a synchronous serial audio port with several transmitters. Software writes one data word per transmitter. At each transmit time slot every transmitter that has a fresh word moves it into the word presented to the serializer. A transmitter that has no fresh word presents its previous word again and reports an underrun. Underruns on the transmitters picked by a select field set a sticky underrun flag.

The flag never requests an interrupt by itself. It only steers a pending transmit interrupt from the ordinary data vector to the exception vector. It is cleared by disabling the port, or by a status read that sees the flag set followed by a write to the data register or the slot register. Which slot strobes count as transmit slots depends on the mode. In normal mode only a strobe with frame sync counts. In network mode every strobe counts.

Top module: `txu_top`

## Requirements
- R1: After reset `tx_empty` is all ones, `tx_word` is all zeros, `undr_flag` is 0 and `tx_vec` is 2'b00.
- R2: A transmit slot is a cycle with `port_en`=1 and `slot_stb`=1 and, when `net_mode`=0, also `fsync`=1. With `net_mode`=1 every strobe counts. A strobe that is not a transmit slot changes no output.
- R3: At a transmit slot a transmitter whose empty bit is 0 copies its stored data word to its `tx_word` lane (lane i is bits i*DW+DW-1 down to i*DW) and sets its empty bit. Both are visible the cycle after the slot.
- R4: At a transmit slot a transmitter whose empty bit is 1 keeps its previous `tx_word` lane unchanged. This is an underrun on that transmitter.
- R5: `dat_wr` with `port_en`=1 stores `wr_data` for transmitter `wr_idx` and clears its empty bit the next cycle. This still holds when a slot falls in the same cycle; the slot then uses the old state. An index of NTX or more is ignored, and so are writes while `port_en`=0.
- R6: `undr_flag` rises the cycle after an underrun on a transmitter whose `tx_sel` bit is 1. Underruns on unselected transmitters leave it unchanged.
- R7: A `sts_rd` while `undr_flag`=1 arms a clear. A later `dat_wr` or `slot_wr` while armed clears the flag the next cycle and disarms. A write with no armed read leaves the flag set. A new underrun in the same cycle as the clear keeps the flag set.
- R8: While `port_en`=0, the next cycle shows `undr_flag` 0, the clear disarmed, all empty bits 1 and all words and stored data 0.
- R9: `tx_vec` is 2'b00 unless `irq_en`=1 and some selected transmitter is empty. In that case it is 2'b01 when `undr_flag`=0 and 2'b10 when `undr_flag`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| port_en | input | 1 | Port enable; low resets the status |
| net_mode | input | 1 | 0 normal mode, 1 network mode |
| fsync | input | 1 | Frame sync |
| slot_stb | input | 1 | Slot strobe from the serializer timing |
| tx_sel | input | NTX | Transmitters that the flag and request reflect |
| irq_en | input | 1 | Transmit interrupt enable |
| sts_rd | input | 1 | Status register read strobe |
| dat_wr | input | 1 | Transmit data register write strobe |
| wr_idx | input | IW | Transmitter addressed by the write |
| wr_data | input | DW | Write data |
| slot_wr | input | 1 | Time-slot register write strobe |
| tx_word | output | NTX*DW | Words presented to the serializer |
| tx_empty | output | NTX | Per-transmitter empty bits |
| undr_flag | output | 1 | Sticky underrun flag |
| tx_vec | output | 2 | Transmit vector select: 00 none, 01 data, 10 exception |

## Verification
The hardest case to reach is a clear sequence that overlaps a fresh underrun, or a sequence broken by a write that comes before the status read. Random bus traffic rarely lines these up with a slot on an empty transmitter that is also selected. Directed steps therefore build each ordering on purpose: a write without a read, a read then a slot-register write, and a clear in the same cycle as a new underrun. Seeded random cycles with about one write per three cycles then mix modes, select masks and brief port disables, and a bench model predicts every output.

// File: rtl/txu_pkg.sv
package txu_pkg;

    typedef enum logic [1:0] {
        VEC_NONE = 2'b00,
        VEC_DATA = 2'b01,
        VEC_EXC  = 2'b10
    } txu_vec_e;

    typedef struct packed {
        logic flag;
        logic arm;
    } txu_flag_t;

endpackage

// File: rtl/txu_slot_gate.sv
module txu_slot_gate (
    input  logic port_en,
    input  logic net_mode,
    input  logic fsync,
    input  logic slot_stb,
    output logic tx_slot
);
    always_comb begin
        tx_slot = 1'b0;
        if (port_en && slot_stb) begin
            tx_slot = net_mode ? 1'b1 : fsync;
        end
    end
endmodule

// File: rtl/txu_lane.sv
module txu_lane #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic          slot,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] word_q,
    output logic          empty_q,
    output logic          undr_evt
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] word;
        logic          empty;
    } lane_t;

    lane_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        undr_evt = slot && st_q.empty;
        if (!port_en) begin
            st_d.data  = '0;
            st_d.word  = '0;
            st_d.empty = 1'b1;
        end else begin
            if (slot && !st_q.empty) begin
                st_d.word  = st_q.data;
                st_d.empty = 1'b1;
            end
            if (wr) begin
                st_d.data  = wdata;
                st_d.empty = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data  <= '0;
            st_q.word  <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q  = st_q.word;
    assign empty_q = st_q.empty;

    // R4
    repeat_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && slot && empty_q) |=> (word_q == $past(word_q)));

    // R3
    fresh_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && slot && !empty_q && !wr) |=> empty_q);

    // R5
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && wr) |=> !empty_q);
endmodule

// File: rtl/txu_flag.sv
module txu_flag #(
    parameter int NTX = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 port_en,
    input  logic [NTX-1:0]       evt,
    input  logic [NTX-1:0]       tx_sel,
    input  logic [NTX-1:0]       empty,
    input  logic                 sts_rd,
    input  logic                 any_wr,
    input  logic                 irq_en,
    output logic                 flag_q,
    output txu_pkg::txu_vec_e    vec
);
    import txu_pkg::*;

    txu_flag_t st_q, st_d;
    logic      hit;
    logic      clr;
    logic      req;

    always_comb begin
        st_d = st_q;
        hit  = |(evt & tx_sel);
        clr  = st_q.arm && any_wr;
        if (!port_en) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end else begin
            if (clr) begin
                st_d.flag = 1'b0;
                st_d.arm  = 1'b0;
            end else if (sts_rd && st_q.flag) begin
                st_d.arm = 1'b1;
            end
            if (hit) begin
                st_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req = irq_en && (|(empty & tx_sel));
        if (!req) begin
            vec = VEC_NONE;
        end else if (st_q.flag) begin
            vec = VEC_EXC;
        end else begin
            vec = VEC_DATA;
        end
    end

    assign flag_q = st_q.flag;

    // R6
    underrun_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && |(evt & tx_sel)) |=> flag_q);

    // R7
    hold_without_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && flag_q && !st_q.arm) |=> flag_q);

    // R7
    armed_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && st_q.arm && any_wr && !(|(evt & tx_sel))) |=> !flag_q);

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!flag_q && !st_q.arm));

    // R9
    exc_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == VEC_EXC) |-> (flag_q && irq_en));
endmodule

// File: rtl/txu_top.sv
module txu_top #(
    parameter int NTX = 3,
    parameter int DW  = 16,
    localparam int IW = (NTX > 1) ? $clog2(NTX) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                port_en,
    input  logic                net_mode,
    input  logic                fsync,
    input  logic                slot_stb,
    input  logic [NTX-1:0]      tx_sel,
    input  logic                irq_en,
    input  logic                sts_rd,
    input  logic                dat_wr,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic                slot_wr,
    output logic [NTX*DW-1:0]   tx_word,
    output logic [NTX-1:0]      tx_empty,
    output logic                undr_flag,
    output logic [1:0]          tx_vec
);
    import txu_pkg::*;

    logic              tx_slot;
    logic [NTX-1:0]    lane_evt;
    logic [NTX-1:0]    lane_wr;
    txu_vec_e          vec_sel;

    txu_slot_gate u_gate (
        .port_en  (port_en),
        .net_mode (net_mode),
        .fsync    (fsync),
        .slot_stb (slot_stb),
        .tx_slot  (tx_slot)
    );

    for (genvar i = 0; i < NTX; i++) begin : g_lane
        assign lane_wr[i] = dat_wr && (int'(wr_idx) == i);

        txu_lane #(.DW(DW)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .port_en  (port_en),
            .slot     (tx_slot),
            .wr       (lane_wr[i]),
            .wdata    (wr_data),
            .word_q   (tx_word[i*DW +: DW]),
            .empty_q  (tx_empty[i]),
            .undr_evt (lane_evt[i])
        );
    end

    txu_flag #(.NTX(NTX)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .evt     (lane_evt),
        .tx_sel  (tx_sel),
        .empty   (tx_empty),
        .sts_rd  (sts_rd),
        .any_wr  (dat_wr || slot_wr),
        .irq_en  (irq_en),
        .flag_q  (undr_flag),
        .vec     (vec_sel)
    );

    assign tx_vec = vec_sel;

    // R2
    no_slot_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !net_mode && !fsync && !dat_wr) |=> $stable(tx_empty));
endmodule

// File: tb/tb_txu_top.sv
module tb_txu_top;
    localparam int NTX = 3;
    localparam int DW  = 16;
    localparam int IW  = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                port_en = 1'b0, net_mode = 1'b0, fsync = 1'b0, slot_stb = 1'b0;
    logic [NTX-1:0]      tx_sel = '0;
    logic                irq_en = 1'b0, sts_rd = 1'b0, dat_wr = 1'b0, slot_wr = 1'b0;
    logic [IW-1:0]       wr_idx = '0;
    logic [DW-1:0]       wr_data = '0;
    logic [NTX*DW-1:0]   tx_word;
    logic [NTX-1:0]      tx_empty;
    logic                undr_flag;
    logic [1:0]          tx_vec;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [DW-1:0] m_word [NTX];
    logic [DW-1:0] m_data [NTX];
    logic [NTX-1:0] m_empty;
    logic m_flag, m_arm;

    always #2.5 clk = ~clk;

    txu_top #(.NTX(NTX), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .net_mode(net_mode),
        .fsync(fsync), .slot_stb(slot_stb), .tx_sel(tx_sel), .irq_en(irq_en),
        .sts_rd(sts_rd), .dat_wr(dat_wr), .wr_idx(wr_idx), .wr_data(wr_data),
        .slot_wr(slot_wr), .tx_word(tx_word), .tx_empty(tx_empty),
        .undr_flag(undr_flag), .tx_vec(tx_vec)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [1:0] exp_vec();
        if (!(irq_en && |(m_empty & tx_sel))) return 2'b00;
        return m_flag ? 2'b10 : 2'b01;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NTX; i++) begin
            m_word[i] = '0;
            m_data[i] = '0;
        end
        m_empty = '1;
        m_flag  = 1'b0;
        m_arm   = 1'b0;
    endtask

    task automatic compare_all();
        for (int i = 0; i < NTX; i++) begin
            chk("R3/R4 word", 64'(tx_word[i*DW +: DW]), 64'(m_word[i]));
        end
        chk("R5 empty", 64'(tx_empty), 64'(m_empty));
        chk("R6/R7 flag", 64'(undr_flag), 64'(m_flag));
        chk("R9 vec", 64'(tx_vec), 64'(exp_vec()));
    endtask

    // One cycle: model advances from the applied inputs, then outputs compared.
    task automatic tick();
        logic slot, ev, clr;
        logic [DW-1:0] n_word [NTX];
        logic [DW-1:0] n_data [NTX];
        logic [NTX-1:0] n_empty;
        logic n_flag, n_arm;
        slot = port_en && slot_stb && (net_mode || fsync);
        ev = 1'b0;
        for (int i = 0; i < NTX; i++) begin
            n_word[i] = m_word[i];
            n_data[i] = m_data[i];
        end
        n_empty = m_empty;
        n_flag = m_flag;
        n_arm = m_arm;
        if (!port_en) begin
            for (int i = 0; i < NTX; i++) begin
                n_word[i] = '0;
                n_data[i] = '0;
            end
            n_empty = '1;
            n_flag = 1'b0;
            n_arm = 1'b0;
        end else begin
            for (int i = 0; i < NTX; i++) begin
                if (slot) begin
                    if (m_empty[i]) ev = ev | tx_sel[i];
                    else begin
                        n_word[i] = m_data[i];
                        n_empty[i] = 1'b1;
                    end
                end
                if (dat_wr && int'(wr_idx) == i) begin
                    n_data[i] = wr_data;
                    n_empty[i] = 1'b0;
                end
            end
            clr = m_arm && (dat_wr || slot_wr);
            if (clr) begin
                n_flag = 1'b0;
                n_arm = 1'b0;
            end else if (sts_rd && m_flag) begin
                n_arm = 1'b1;
            end
            if (ev) n_flag = 1'b1;
        end
        @(posedge clk);
        for (int i = 0; i < NTX; i++) begin
            m_word[i] = n_word[i];
            m_data[i] = n_data[i];
        end
        m_empty = n_empty;
        m_flag = n_flag;
        m_arm = n_arm;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        slot_stb = 0; fsync = 0; sts_rd = 0; dat_wr = 0; slot_wr = 0;
    endtask

    task automatic write(input int idx, input logic [DW-1:0] v);
        idle();
        dat_wr = 1; wr_idx = IW'(idx); wr_data = v;
        tick();
        dat_wr = 0;
    endtask

    task automatic slot_pulse(input logic fs);
        idle();
        slot_stb = 1; fsync = fs;
        tick();
        idle();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 empty", 64'(tx_empty), 64'h7);
        chk("R1 word", 64'(tx_word), 64'h0);
        chk("R1 flag", 64'(undr_flag), 64'h0);
        chk("R1 vec", 64'(tx_vec), 64'h0);
        rst_n = 1;
        @(negedge clk);
        port_en = 1; tx_sel = 3'b111; irq_en = 1; net_mode = 0;
        idle();
        tick();
        write(0, 16'hA5A5); write(1, 16'h1234); write(2, 16'hBEEF);
        write(3, 16'hDEAD); // R5 out-of-range index ignored
        chk("R5 data written", 64'(tx_empty), 64'h0);
        chk("R9 no request when full", 64'(tx_vec), 64'h0);
        // R2 normal mode, strobe without frame sync is no slot
        slot_pulse(1'b0);
        chk("R2 no fsync", 64'(tx_empty), 64'h0);
        slot_pulse(1'b1);
        chk("R3 fresh word lane1", 64'(tx_word[DW +: DW]), 64'h1234);
        chk("R3 empty set", 64'(tx_empty), 64'h7);
        chk("R9 data vector", 64'(tx_vec), 64'h1);
        // R6 underrun on unselected lane only
        write(1, 16'h0101); write(2, 16'h0202);
        tx_sel = 3'b110;
        slot_pulse(1'b1);
        chk("R6 unselected underrun", 64'(undr_flag), 64'h0);
        chk("R4 repeat lane0", 64'(tx_word[0 +: DW]), 64'hA5A5);
        tx_sel = 3'b111;
        slot_pulse(1'b1);
        chk("R6 selected underrun", 64'(undr_flag), 64'h1);
        chk("R9 exception vector", 64'(tx_vec), 64'h2);
        // R7 write without armed read keeps the flag
        write(0, 16'h5555);
        chk("R7 write without read", 64'(undr_flag), 64'h1);
        idle(); sts_rd = 1; tick();
        idle(); slot_wr = 1; tick(); idle();
        chk("R7 read then slot write", 64'(undr_flag), 64'h0);
        // R7 clear coinciding with new underrun
        net_mode = 1;
        slot_pulse(1'b0); // R2 network mode: lane0 fresh, others underrun
        chk("R2 network slot", 64'(undr_flag), 64'h1);
        idle(); sts_rd = 1; tick();
        idle(); dat_wr = 1; wr_idx = 0; wr_data = 16'h7777; slot_stb = 1; tick(); idle();
        chk("R7 set wins over clear", 64'(undr_flag), 64'h1);
        // R8 disable
        port_en = 0; write(1, 16'h9999);
        chk("R8 flag cleared", 64'(undr_flag), 64'h0);
        chk("R8 empty set", 64'(tx_empty), 64'h7);
        chk("R5 write ignored when disabled", 64'(tx_word), 64'h0);
        port_en = 1; idle(); tick();

        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            slot_stb = ($urandom % 100) < 40;
            fsync    = ($urandom % 2) == 1;
            dat_wr   = ($urandom % 100) < 35;
            sts_rd   = ($urandom % 100) < 20;
            slot_wr  = ($urandom % 100) < 5;
            wr_idx   = IW'($urandom % 4);
            wr_data  = DW'($urandom);
            if (n % 200 == 0) begin
                net_mode = $urandom % 2;
                tx_sel   = NTX'($urandom);
                irq_en   = $urandom % 2;
            end
            port_en = ($urandom % 100) < 98;
            tick();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule